// File: doc/BRIEF.md
# Reset Vector Boot Sequencer

This block runs once after every reset, before the instruction fetch pipeline starts. It first waits a short, fixed number of cycles so that neighbouring units can finish coming out of reset. It then makes two reads over a simple request/valid memory port. Both reads target words at the very top of the address space. The first read gives the initial stack pointer. The second read gives the initial program counter.

The fetched program counter is not used as it arrives. It is moved up by 12 bit positions, so the low 12 bits of the PC register form a micro-code instruction pointer that starts at zero. Once the PC is loaded, the block raises a fetch-enable output. That output stays high until the next reset.

Until that moment, any exception request coming in is masked, so that a redirect cannot act on a PC that has not been loaded. The block also provides the target of a relative displacement. This target is computed from the PC bits above the micro-code field only.

Top module: `boot_vector_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, `fetch_en_o` and `mem_req_o` are 0 and `sp_o` and `pc_o` read 0.
- R2: `mem_req_o` first goes high exactly HOLD_CYC clock edges after reset is released (default 6), and is low before that.
- R3: The first request uses address 2^ADDR_W − 2·(DATA_W/8), which is 0xFFFFFFF8 by default. The data returned for it appears on `sp_o` one cycle after `mem_rvalid_i`.
- R4: The second request is issued in the cycle after the stack-pointer response, at address 2^ADDR_W − DATA_W/8 (0xFFFFFFFC by default).
- R5: After the PC response, `pc_o` equals the returned word shifted left by 12, with bits [11:0] equal to 0.
- R6: Each request is high for exactly one cycle. The block then waits any number of cycles for `mem_rvalid_i`. A `mem_rvalid_i` in the request cycle itself, or after the sequence ends, has no effect on `sp_o` or `pc_o`.
- R7: `fetch_en_o` rises one cycle after the PC response and stays high until reset.
- R8: `exc_pend_o` is 0 while `fetch_en_o` is 0, and it equals `exc_pend_i` once `fetch_en_o` is 1.
- R9: `branch_tgt_o` equals `{pc_o[PC_W-1:12] + disp_i, 12'h000}`, where the upper sum wraps at DATA_W bits.
- R10: A reset at any point during the sequence returns the block to the R1 state, and the whole sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req_o | output | 1 | Single-cycle read request |
| mem_addr_o | output | ADDR_W | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| exc_pend_i | input | 1 | Raw exception-pending request |
| exc_pend_o | output | 1 | Exception request, masked until boot completes |
| disp_i | input | DATA_W | Relative displacement, in units above the micro-code field |
| sp_o | output | DATA_W | Initial stack pointer |
| pc_o | output | DATA_W+12 | Program counter, with the micro-code pointer in bits [11:0] |
| branch_tgt_o | output | DATA_W+12 | Relative target built from the upper PC bits |
| fetch_en_o | output | 1 | Fetch release, sticky until reset |

## Verification
The bench sweeps response latencies from zero upward and checks the exact cycle of the first request. An off-by-one hold counter would issue the first read a cycle early or late. It drives a stray valid during the request cycle, which a sequencer that samples too eagerly would latch as the stack pointer. It raises the exception input during boot, which would redirect an unloaded PC if masking were missing. It also checks the 12-bit shift and the top-of-memory addresses, where a dropped shift or swapped vectors would show up at once. It applies a reset in the middle of a read, which a sequencer that keeps stale state would fail to restart.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    S_HOLD    = 3'd0,
    S_ASK_SP  = 3'd1,
    S_WAIT_SP = 3'd2,
    S_ASK_PC  = 3'd3,
    S_WAIT_PC = 3'd4,
    S_RUN     = 3'd5
  } boot_state_e;
endpackage

// File: rtl/boot_hold_timer.sv
module boot_hold_timer #(
  parameter int HOLD_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  output logic expired_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LAST);

  // R2: once expired, the timer stays expired until reset
  a_r2_timer_sticky: assert property (@(posedge clk) disable iff (rst)
    expired_o |=> expired_o);
endmodule

// File: rtl/boot_vector_fsm.sv
module boot_vector_fsm
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_done_i,
  input  logic              mem_rvalid_i,
  output boot_state_e       state_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              sp_ld_o,
  output logic              pc_ld_o
);
  localparam int WB = DATA_W / 8;
  localparam logic [ADDR_W-1:0] PC_VEC = ~ADDR_W'(WB - 1);
  localparam logic [ADDR_W-1:0] SP_VEC = PC_VEC - ADDR_W'(WB);

  boot_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_HOLD:    if (hold_done_i)  st_d = S_ASK_SP;
      S_ASK_SP:                    st_d = S_WAIT_SP;
      S_WAIT_SP: if (mem_rvalid_i) st_d = S_ASK_PC;
      S_ASK_PC:                    st_d = S_WAIT_PC;
      S_WAIT_PC: if (mem_rvalid_i) st_d = S_RUN;
      default:                     st_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= S_HOLD;
    else     st_q <= st_d;
  end

  assign state_o    = st_q;
  assign mem_req_o  = (st_q == S_ASK_SP) || (st_q == S_ASK_PC);
  assign mem_addr_o = (st_q == S_ASK_PC) ? PC_VEC : SP_VEC;
  assign sp_ld_o    = (st_q == S_WAIT_SP) && mem_rvalid_i;
  assign pc_ld_o    = (st_q == S_WAIT_PC) && mem_rvalid_i;

  // R6: a request lasts exactly one cycle
  a_r6_req_single: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);
  // R4: a PC load is only possible after the stack pointer was loaded earlier
  a_r4_pc_after_sp: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_o) && (mem_addr_o == PC_VEC) |-> $past(sp_ld_o));
endmodule

// File: rtl/boot_pc_regs.sv
module boot_pc_regs #(
  parameter int DATA_W = 32,
  parameter int UIP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sp_ld_i,
  input  logic                    pc_ld_i,
  input  logic [DATA_W-1:0]       rdata_i,
  input  logic [DATA_W-1:0]       disp_i,
  output logic [DATA_W-1:0]       sp_o,
  output logic [DATA_W+UIP_W-1:0] pc_o,
  output logic [DATA_W+UIP_W-1:0] tgt_o
);
  localparam int PC_W = DATA_W + UIP_W;

  // place a fetched vector above the micro-code pointer field
  function automatic logic [PC_W-1:0] place_vector(input logic [DATA_W-1:0] v);
    return {v, {UIP_W{1'b0}}};
  endfunction

  // relative target: add displacement to the macro part only
  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] pc,
                                                 input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] hi;
    hi = pc[PC_W-1:UIP_W] + d;
    return {hi, {UIP_W{1'b0}}};
  endfunction

  logic [DATA_W-1:0] sp_q;
  logic [PC_W-1:0]   pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
      pc_q <= '0;
    end else begin
      if (sp_ld_i) sp_q <= rdata_i;
      if (pc_ld_i) pc_q <= place_vector(rdata_i);
    end
  end

  assign sp_o  = sp_q;
  assign pc_o  = pc_q;
  assign tgt_o = rel_target(pc_q, disp_i);

  // R5: the micro-code pointer is zero after a vector load
  a_r5_uip_zero: assert property (@(posedge clk) disable iff (rst)
    pc_ld_i |=> (pc_o[UIP_W-1:0] == '0));
  // R6: the stack pointer changes only through a load
  a_r6_sp_stable: assert property (@(posedge clk) disable iff (rst)
    !sp_ld_i |=> $stable(sp_o));
endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int UIP_W    = 12,
  parameter int HOLD_CYC = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  input  logic                    exc_pend_i,
  output logic                    exc_pend_o,
  input  logic [DATA_W-1:0]       disp_i,
  output logic [DATA_W-1:0]       sp_o,
  output logic [DATA_W+UIP_W-1:0] pc_o,
  output logic [DATA_W+UIP_W-1:0] branch_tgt_o,
  output logic                    fetch_en_o
);
  logic        hold_done;
  logic        sp_ld, pc_ld;
  boot_state_e state;

  boot_hold_timer #(.HOLD_CYC(HOLD_CYC)) timer_i (
    .clk(clk), .rst(rst), .expired_o(hold_done)
  );

  boot_vector_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
    .clk(clk), .rst(rst), .hold_done_i(hold_done), .mem_rvalid_i(mem_rvalid_i),
    .state_o(state), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .sp_ld_o(sp_ld), .pc_ld_o(pc_ld)
  );

  boot_pc_regs #(.DATA_W(DATA_W), .UIP_W(UIP_W)) regs_i (
    .clk(clk), .rst(rst), .sp_ld_i(sp_ld), .pc_ld_i(pc_ld),
    .rdata_i(mem_rdata_i), .disp_i(disp_i),
    .sp_o(sp_o), .pc_o(pc_o), .tgt_o(branch_tgt_o)
  );

  assign fetch_en_o = (state == S_RUN);
  assign exc_pend_o = exc_pend_i && fetch_en_o;

  // R7: fetch stays released until reset
  a_r7_fetch_sticky: assert property (@(posedge clk) disable iff (rst)
    fetch_en_o |=> fetch_en_o);
  // R7: release follows a PC load
  a_r7_fetch_after_pc: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_en_o) |-> $past(pc_ld));
  // R8: no exception passes before boot completes
  a_r8_exc_masked: assert property (@(posedge clk) disable iff (rst)
    !fetch_en_o |-> !exc_pend_o);
  // R2: no request during the hold window
  a_r2_no_early_req: assert property (@(posedge clk) disable iff (rst)
    !hold_done |-> !mem_req_o);
endmodule

// File: tb/boot_vector_seq_tb.sv
module boot_vector_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int UIP_W  = 12;
  localparam int HOLD   = 6;
  localparam int PC_W   = DATA_W + UIP_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_req, mem_rvalid = 1'b0, exc_i = 1'b0, exc_o, fetch_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata = '0, disp = '0, sp;
  logic [PC_W-1:0]   pc, tgt;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_vector_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UIP_W(UIP_W), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst(rst), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .exc_pend_i(exc_i), .exc_pend_o(exc_o), .disp_i(disp),
    .sp_o(sp), .pc_o(pc), .branch_tgt_o(tgt), .fetch_en_o(fetch_en)
  );

  function automatic logic [ADDR_W-1:0] exp_sp_addr();
    longint unsigned top = longint'(1) << ADDR_W;
    return ADDR_W'(top - 2 * (DATA_W / 8));
  endfunction

  function automatic logic [ADDR_W-1:0] exp_pc_addr();
    longint unsigned top = longint'(1) << ADDR_W;
    return ADDR_W'(top - (DATA_W / 8));
  endfunction

  function automatic logic [PC_W-1:0] exp_pc(input logic [DATA_W-1:0] v);
    logic [PC_W-1:0] w = PC_W'(v);
    return w << UIP_W;
  endfunction

  function automatic logic [PC_W-1:0] exp_tgt(input logic [DATA_W-1:0] v,
                                              input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] s = v + d;
    return exp_pc(s);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(fetch_en == 1'b0, req, 64'(fetch_en), 0);
    chk(mem_req == 1'b0, req, 64'(mem_req), 0);
    chk(sp == '0, req, 64'(sp), 0);
    chk(pc == '0, req, 64'(pc), 0);
  endtask

  task automatic run_boot(input logic [DATA_W-1:0] spv, input logic [DATA_W-1:0] pcv,
                          input int lsp, input int lpc, input bit stray);
    @(negedge clk);
    rst = 1'b1; mem_rvalid = 1'b0; exc_i = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 first cycle after reset");
    repeat (HOLD - 2) @(negedge clk);
    chk(mem_req == 1'b0, "R2 no request before hold ends", 64'(mem_req), 0);
    @(negedge clk);
    chk(mem_req == 1'b1, "R2 request after hold", 64'(mem_req), 1);
    chk(mem_addr == exp_sp_addr(), "R3 stack vector address", 64'(mem_addr), 64'(exp_sp_addr()));
    chk(exc_o == 1'b0, "R8 exception masked", 64'(exc_o), 0);
    if (stray) begin
      mem_rvalid = 1'b1; mem_rdata = ~spv;
    end
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk(mem_req == 1'b0, "R6 request single cycle", 64'(mem_req), 0);
    chk(sp == '0, "R6 stray valid ignored", 64'(sp), 0);
    repeat (lsp) begin
      @(negedge clk);
      chk(mem_req == 1'b0 && sp == '0, "R6 waiting for stack data", 64'(sp), 0);
    end
    mem_rvalid = 1'b1; mem_rdata = spv;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = '0;
    chk(sp == spv, "R3 stack pointer loaded", 64'(sp), 64'(spv));
    chk(mem_req == 1'b1, "R4 second request", 64'(mem_req), 1);
    chk(mem_addr == exp_pc_addr(), "R4 pc vector address", 64'(mem_addr), 64'(exp_pc_addr()));
    @(negedge clk);
    chk(fetch_en == 1'b0, "R7 fetch held during pc read", 64'(fetch_en), 0);
    repeat (lpc) @(negedge clk);
    chk(exc_o == 1'b0, "R8 exception masked in pc wait", 64'(exc_o), 0);
    mem_rvalid = 1'b1; mem_rdata = pcv;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk(fetch_en == 1'b1, "R7 fetch released", 64'(fetch_en), 1);
    chk(pc == exp_pc(pcv), "R5 pc shifted by 12", 64'(pc), 64'(exp_pc(pcv)));
    chk(exc_o == 1'b1, "R8 exception passes after boot", 64'(exc_o), 1);
    exc_i = 1'b0;
    #1;
    chk(exc_o == 1'b0, "R8 exception follows input", 64'(exc_o), 0);
  endtask

  task automatic after_boot_checks(input logic [DATA_W-1:0] spv, input logic [DATA_W-1:0] pcv);
    for (int i = 0; i < 3; i++) begin
      mem_rvalid = 1'b1; mem_rdata = $urandom();
      @(negedge clk);
    end
    mem_rvalid = 1'b0;
    chk(fetch_en == 1'b1, "R7 fetch stays high", 64'(fetch_en), 1);
    chk(pc == exp_pc(pcv) && sp == spv, "R6 late valid ignored", 64'(pc), 64'(exp_pc(pcv)));
    disp = $urandom();
    #1;
    chk(tgt == exp_tgt(pcv, disp), "R9 relative target", 64'(tgt), 64'(exp_tgt(pcv, disp)));
    disp = '1;
    #1;
    chk(tgt == exp_tgt(pcv, disp), "R9 negative displacement", 64'(tgt), 64'(exp_tgt(pcv, disp)));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // directed: zero latency, all-ones vectors
    run_boot(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1'b0);
    after_boot_checks(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // directed: stray valid in request cycle
    run_boot(32'h0000_8000, 32'h0000_0001, 2, 3, 1'b1);
    after_boot_checks(32'h0000_8000, 32'h0000_0001);
    // directed: reset mid-sequence (R10)
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (HOLD) @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R10 reset during stack wait");
    run_boot(32'hA5A5_0F0F, 32'h1234_5678, 1, 1, 1'b0);
    after_boot_checks(32'hA5A5_0F0F, 32'h1234_5678);
    // random sweep
    for (int k = 0; k < 20; k++) begin
      logic [DATA_W-1:0] s, p;
      s = $urandom(); p = $urandom();
      run_boot(s, p, int'($urandom_range(0, 6)), int'($urandom_range(0, 6)), 1'($urandom()));
      after_boot_checks(s, p);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule